// File: doc/BRIEF.md
# Edge-Triggered Pulse-Width One-Shot

This block turns each rising edge of a trigger input into exactly one output pulse. After the trigger it waits for a fixed lead interval. It then drives the output high for a number of system clock ticks given by an 8-bit width code. A code below the smallest usable width is raised to that minimum. The width code is captured in the cycle that accepts the trigger, so the code input may change freely while a pulse is in progress.

The one-shot cannot be retriggered. Trigger edges that arrive during the lead interval or the high phase are ignored: they neither restart the pulse nor extend it. The earliest trigger that can be accepted therefore comes lead plus width ticks after the previous one, and the output repetition rate follows the trigger rate. A trigger only needs to stay high for one clock. When the enable from the mode selection is low, the output is held low and the sequencer stays idle.

Top module: `pwm_oneshot`

## Requirements
- R1: Only a low-to-high change of `trigIn` between two consecutive clock samples starts a pulse. A trigger held high starts one pulse and no more.
- R2: If the trigger edge is sampled at clock edge E, `pwmOut` goes high at edge E+4 (LEAD_TICKS = 4). It is low from E up to that edge.
- R3: For a latched code of 2 or more, `pwmOut` stays high for exactly that many clock ticks and goes low at edge E+4+code.
- R4: Codes 0 and 1 give a pulse 2 ticks wide (MIN_WIDTH = 2).
- R5: Trigger edges sampled during the lead interval or the high phase do not restart or lengthen the pulse.
- R6: A one-cycle trigger gives a full pulse. The code is captured at edge E, and changes to `codeIn` after E do not affect the width.
- R7: A trigger edge sampled at the edge where the pulse ends (E+4+width) is accepted, and the next pulse rises 4 ticks later. An edge sampled one tick earlier is ignored.
- R8: While `enable` is low, `pwmOut` is low from the next clock edge on and trigger edges are ignored.
- R9: While `rstN` is low, `pwmOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every interval counts its rising edges |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Enables one-shot operation; when low, the output is forced low |
| trigIn | input | 1 | Trigger; its rising edge starts a pulse |
| codeIn | input | 8 | Pulse width code in ticks, captured on trigger |
| pwmOut | output | 1 | Pulse output |

## Verification
A wrong sequencer state shows directly at `pwmOut`. A stuck lead counter or width counter moves the rising or falling edge by whole ticks, and the move is visible within the same pulse. A wrong busy indication shows as a second pulse or a stretched pulse when triggers are spaced just inside or just outside the lead-plus-width window. A corrupted captured width shows once the code input is changed after the trigger, at the falling edge of that pulse, at most 255 ticks later.

// File: rtl/pwm_oneshot_pkg.sv
package pwm_oneshot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_HIGH = 2'd2
  } osState_t;

  typedef struct packed {
    logic loadLead;   // start lead interval, capture width
    logic loadWidth;  // start high phase
    logic countDown;  // decrement interval counter
    logic setPwm;     // drive output high
    logic clrPwm;     // drive output low
  } dpStrobe_t;

endpackage

// File: rtl/pwm_oneshot_dp.sv
module pwm_oneshot_dp
  import pwm_oneshot_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int LEAD_TICKS = 4,
  parameter int MIN_WIDTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic [CODE_W-1:0] codeIn,
  input  dpStrobe_t         strb,
  output logic              trigRise,
  output logic              cntZero,
  output logic              pwmOut
);

  localparam logic [CODE_W-1:0] LEAD_LOAD = CODE_W'(LEAD_TICKS - 1);
  localparam logic [CODE_W-1:0] MIN_W     = CODE_W'(MIN_WIDTH);

  logic              trigPrev;
  logic [CODE_W-1:0] cnt;
  logic [CODE_W-1:0] widthReg;
  logic [CODE_W-1:0] clampedW;
  logic              pwmReg;

  assign trigRise = trigIn & ~trigPrev;
  assign cntZero  = (cnt == '0);
  assign clampedW = (codeIn < MIN_W) ? MIN_W : codeIn;
  assign pwmOut   = pwmReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= 1'b0;
    end else begin
      trigPrev <= trigIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      widthReg <= MIN_W;
    end else if (strb.loadLead) begin
      cnt      <= LEAD_LOAD;
      widthReg <= clampedW;
    end else if (strb.loadWidth) begin
      cnt <= widthReg - 1'b1;
    end else if (strb.countDown) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmReg <= 1'b0;
    end else if (strb.clrPwm) begin
      pwmReg <= 1'b0;
    end else if (strb.setPwm) begin
      pwmReg <= 1'b1;
    end
  end

  // R4
  width_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    widthReg >= MIN_W)
    else $error("captured width below minimum");

  // R6
  width_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadLead |=> $stable(widthReg))
    else $error("captured width changed without a trigger");

endmodule

// File: rtl/pwm_oneshot_ctrl.sv
module pwm_oneshot_ctrl
  import pwm_oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      trigRise,
  input  logic      cntZero,
  input  logic      pwmOut,
  output dpStrobe_t strb
);

  osState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    if (!enable) begin
      stateNxt    = ST_IDLE;
      strb.clrPwm = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trigRise) begin
            stateNxt      = ST_LEAD;
            strb.loadLead = 1'b1;
          end
        end
        ST_LEAD: begin
          if (cntZero) begin
            stateNxt       = ST_HIGH;
            strb.loadWidth = 1'b1;
            strb.setPwm    = 1'b1;
          end else begin
            strb.countDown = 1'b1;
          end
        end
        ST_HIGH: begin
          if (cntZero) begin
            strb.clrPwm = 1'b1;
            if (trigRise) begin
              stateNxt      = ST_LEAD;
              strb.loadLead = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
            end
          end else begin
            strb.countDown = 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  // R2
  lead_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LEAD) |-> !pwmOut)
    else $error("output high during lead interval");

  // R2
  rise_from_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> ($past(state) == ST_LEAD) && $past(cntZero))
    else $error("output rose outside end of lead");

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && !cntZero && enable) |=> (state == ST_HIGH) && pwmOut)
    else $error("pulse interrupted or restarted");

  // R3
  fall_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwmOut) |-> ($past(state) == ST_HIGH) && ($past(cntZero) || !$past(enable)))
    else $error("output fell before width elapsed");

endmodule

// File: rtl/pwm_oneshot.sv
module pwm_oneshot
  import pwm_oneshot_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int LEAD_TICKS = 4,
  parameter int MIN_WIDTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              trigIn,
  input  logic [CODE_W-1:0] codeIn,
  output logic              pwmOut
);

  dpStrobe_t strb;
  logic      trigRise;
  logic      cntZero;

  pwm_oneshot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .trigRise (trigRise),
    .cntZero  (cntZero),
    .pwmOut   (pwmOut),
    .strb     (strb)
  );

  pwm_oneshot_dp #(
    .CODE_W     (CODE_W),
    .LEAD_TICKS (LEAD_TICKS),
    .MIN_WIDTH  (MIN_WIDTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .codeIn   (codeIn),
    .strb     (strb),
    .trigRise (trigRise),
    .cntZero  (cntZero),
    .pwmOut   (pwmOut)
  );

  // R8
  disable_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut)
    else $error("output high while disabled");

endmodule

// File: tb/pwm_oneshot_bench.sv
`timescale 1ns/1ps
module pwm_oneshot_bench;

  localparam int LEAD  = 4;
  localparam int MINW  = 2;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       trigIn = 1'b0;
  logic [7:0] codeIn = 8'd0;
  logic       pwmOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int riseCyc = -1, firstRise = -1, fallCyc = -1, riseCount = 0;
  logic pwmSeen = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_oneshot u_pwm_oneshot (
    .clk(clk), .rstN(rstN), .enable(enable),
    .trigIn(trigIn), .codeIn(codeIn), .pwmOut(pwmOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pwmOut && !pwmSeen) begin
      if (riseCount == 0) firstRise = cyc;
      riseCyc = cyc;
      riseCount++;
    end
    if (!pwmOut && pwmSeen) fallCyc = cyc;
    pwmSeen = pwmOut;
  end

  always @(posedge clk) begin
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d (expected end before %0d)", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    riseCyc = -1; firstRise = -1; fallCyc = -1; riseCount = 0;
  endtask

  function automatic int expW(input int c);
    return (c < MINW) ? MINW : c;
  endfunction

  // Trigger with a given code and length; scramble the code afterwards (R6).
  task automatic runPulse(input int code, input int trigLen, input string req);
    int c0, w;
    @(negedge clk);
    clearMon();
    codeIn = 8'(code);
    trigIn = 1'b1;
    c0 = cyc + 1;
    w = expW(code);
    @(negedge clk);
    codeIn = ~8'(code);
    repeat (trigLen - 1) @(negedge clk);
    trigIn = 1'b0;
    repeat (LEAD + w + 2) @(negedge clk);
    check(riseCyc == c0 + LEAD, {req, " rise R2"}, riseCyc, c0 + LEAD);
    check(fallCyc == c0 + LEAD + w, {req, " width R3/R4/R6"}, fallCyc, c0 + LEAD + w);
    check(riseCount == 1, {req, " single pulse R6"}, riseCount, 1);
  endtask

  initial begin
    int c0;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R9 reset low", int'(pwmOut), 0);
    rstN = 1'b1;
    enable = 1'b1;
    repeat (2) @(negedge clk);
    check(pwmOut == 1'b0, "R9 idle low after reset", int'(pwmOut), 0);

    // R3 R4 R6: sweep every code with trigger lengths 1..3
    for (int code = 0; code < 256; code++) begin
      runPulse(code, 1 + (code % 3), code < MINW ? "R4 clamp" : "R3 sweep");
    end

    // R1: level held high gives one pulse
    @(negedge clk);
    clearMon();
    codeIn = 8'd3;
    trigIn = 1'b1;
    repeat (100) @(negedge clk);
    check(riseCount == 1, "R1 held level", riseCount, 1);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R5: toggling trigger during lead and pulse
    clearMon();
    codeIn = 8'd20;
    trigIn = 1'b1;
    c0 = cyc + 1;
    while (cyc < c0 + 20) begin
      @(negedge clk);
      trigIn = ~trigIn;
    end
    trigIn = 1'b0;
    repeat (30) @(negedge clk);
    check(riseCyc == c0 + LEAD, "R5 rise not moved", riseCyc, c0 + LEAD);
    check(fallCyc == c0 + LEAD + 20, "R5 not extended", fallCyc, c0 + LEAD + 20);
    check(riseCount == 1, "R5 no restart", riseCount, 1);

    // R7: back-to-back at the end edge is accepted
    @(negedge clk);
    clearMon();
    codeIn = 8'd5;
    trigIn = 1'b1;
    c0 = cyc + 1;
    @(negedge clk);
    trigIn = 1'b0;
    while (cyc != c0 + LEAD + 5 - 1) @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
    repeat (20) @(negedge clk);
    check(riseCount == 2, "R7 second accepted", riseCount, 2);
    check(firstRise == c0 + LEAD, "R7 first rise", firstRise, c0 + LEAD);
    check(riseCyc == c0 + 2*LEAD + 5, "R7 second rise", riseCyc, c0 + 2*LEAD + 5);
    check(fallCyc == c0 + 2*LEAD + 10, "R7 second fall", fallCyc, c0 + 2*LEAD + 10);

    // R7: one tick early is ignored
    clearMon();
    codeIn = 8'd5;
    trigIn = 1'b1;
    c0 = cyc + 1;
    @(negedge clk);
    trigIn = 1'b0;
    while (cyc != c0 + LEAD + 5 - 2) @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
    repeat (20) @(negedge clk);
    check(riseCount == 1, "R7 early edge ignored", riseCount, 1);

    // R8: disable mid-pulse forces low next edge
    clearMon();
    codeIn = 8'd30;
    trigIn = 1'b1;
    c0 = cyc + 1;
    @(negedge clk);
    trigIn = 1'b0;
    while (cyc != c0 + 10) @(negedge clk);
    check(pwmOut == 1'b1, "R8 pulse active before disable", int'(pwmOut), 1);
    enable = 1'b0;
    @(negedge clk);
    check(pwmOut == 1'b0, "R8 low after disable", int'(pwmOut), 0);
    for (int k = 0; k < 4; k++) begin
      trigIn = 1'b1;
      @(negedge clk);
      trigIn = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    check(riseCount == 1, "R8 triggers ignored while disabled", riseCount, 1);
    check(pwmOut == 1'b0, "R8 stays low while disabled", int'(pwmOut), 0);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    check(pwmOut == 1'b0, "R8 idle after re-enable", int'(pwmOut), 0);
    runPulse(7, 1, "R8 works after re-enable");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule